// File: doc/BRIEF.md
# GPIO Pin-Change Interrupt Controller

This block watches one 8-bit general-purpose input port and raises an interrupt when a watched pin takes a level it should not. Each pin has its own enable bit and its own choice of reference. The reference is either the level the pin had one clock earlier, or a level programmed in a per-pin expected-value register. Every pin first passes through a two-flop synchronizer and then an optional per-pin inversion. All further logic works on this logical value, which is also returned as the port value.

When the first enabled mismatch is seen, the block records which pins caused it in a flag register. It stores a snapshot of the logical port value in a capture register and asserts its interrupt line. Flags and snapshot stay frozen while the interrupt is pending. The interrupt is released only when the register bus signals a read of the port value or of the capture register. A mismatch that is still present after that read raises the interrupt again on the following clock.

The interrupt line can be active-high or active-low. It can be driven at all times, or it can use an output enable that is set only while the interrupt is active, which gives open-drain behaviour.

Top module: `gpio_change_irq`

## Requirements
- R1: After reset the flag and capture registers read 0, the interrupt is inactive, and the output enable equals the push-pull select.
- R2: `portVal` follows `pinIn` XOR `polInv`. A pin change becomes visible on `portVal` after the second rising clock edge, and it is not yet visible after the first.
- R3: A 1 in bit n of `polInv` inverts pin n as seen by `portVal`, the comparison and the capture register.
- R4: With `cmpSel` bit n = 0 and `intEn` bit n = 1, a change of logical pin n sets flag bit n and asserts the interrupt on the third rising edge after the pin change, and not before that edge.
- R5: With `cmpSel` bit n = 1 and `intEn` bit n = 1, a logical pin n level that differs from `defVal` bit n sets flag bit n and asserts the interrupt.
- R6: A pin whose `intEn` bit is 0 never sets its flag and never causes an interrupt.
- R7: When the interrupt is raised, `intCapture` holds the logical port value of that cycle. Flags and capture stay unchanged while the interrupt is pending, whatever the pins do.
- R8: A one-cycle pulse on `rdPortStrb` or on `rdCapStrb` clears the pending interrupt and the flags at the next rising edge. The capture register keeps its value.
- R9: If a compare-to-default mismatch is still present after the clearing read, the interrupt is raised again one clock later, with the flags reloaded.
- R10: `irqActiveHigh` = 1 makes `irqOut` 1 while the interrupt is active and 0 otherwise. `irqActiveHigh` = 0 gives the opposite levels.
- R11: With `irqPushPull` = 1, `irqOe` is always 1. With `irqPushPull` = 0, `irqOe` is 1 only while the interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinIn | input | 8 | Raw pin levels (asynchronous) |
| polInv | input | 8 | Per-pin inversion select |
| intEn | input | 8 | Per-pin interrupt enable |
| cmpSel | input | 8 | Per-pin reference: 0 = previous value, 1 = defVal |
| defVal | input | 8 | Expected level per pin for compare-to-default |
| irqActiveHigh | input | 1 | Interrupt level select, 1 = active high |
| irqPushPull | input | 1 | 1 = always driven, 0 = open-drain via irqOe |
| rdPortStrb | input | 1 | Bus read of the port value (clears interrupt) |
| rdCapStrb | input | 1 | Bus read of the capture register (clears interrupt) |
| portVal | output | 8 | Synchronized, polarity-adjusted port value |
| intFlags | output | 8 | Pins that caused the pending interrupt |
| intCapture | output | 8 | Port value captured when the interrupt was raised |
| irqOut | output | 1 | Interrupt pin level |
| irqOe | output | 1 | Interrupt pin output enable |

## Verification
A pin change needs two edges to reach `portVal` and a third edge to reach the flags, the capture register and the interrupt. The bench therefore samples on the falling edge after the second rising edge, where the interrupt must still be idle, and again after the third, where it must be active. Changes to enable, reference or inversion act on the comparison directly, so they raise the interrupt one edge after they are applied. A clearing strobe acts at the next edge, and a re-raise is due one edge after that. Every sample is taken on a falling edge counted from the stimulus, never on the edge where a result changes.

// File: rtl/gpio_change_irq_pkg.sv
package gpio_change_irq_pkg;
  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic load;   // latch flags and snapshot this cycle
    logic clear;  // drop flags this cycle
  } irqStrobe_t;
endpackage

// File: rtl/gpio_change_irq_dp.sv
module gpio_change_irq_dp
  import gpio_change_irq_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] polInv,
  input  logic [WIDTH-1:0] intEn,
  input  logic [WIDTH-1:0] cmpSel,
  input  logic [WIDTH-1:0] defVal,
  input  irqStrobe_t       strb,
  output logic [WIDTH-1:0] portVal,
  output logic [WIDTH-1:0] hitVec,
  output logic [WIDTH-1:0] intFlags,
  output logic [WIDTH-1:0] intCapture
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] prevVal;
  logic [WIDTH-1:0] refVal;

  // Synchronizer chain in front of all comparison logic
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= '0;
        else       syncQ[g] <= pinIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= '0;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  assign portVal = syncQ[LAST] ^ polInv;

  // Previous-value reference follows the logical value every cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevVal <= '0;
    else       prevVal <= portVal;
  end

  // Per-pin reference selection
  for (genvar b = 0; b < WIDTH; b++) begin : gRef
    assign refVal[b] = cmpSel[b] ? defVal[b] : prevVal[b];
  end

  assign hitVec = intEn & (portVal ^ refVal);

  // Flag and snapshot registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intFlags   <= '0;
      intCapture <= '0;
    end else if (strb.clear) begin
      intFlags   <= '0;
    end else if (strb.load) begin
      intFlags   <= hitVec;
      intCapture <= portVal;
    end
  end

  AST_SNAPSHOT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(intCapture)) else $error("snapshot moved without load"); // R7
  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.clear) |=> (intFlags != '0)) else $error("load left flags empty"); // R4
endmodule

// File: rtl/gpio_change_irq_ctl.sv
module gpio_change_irq_ctl
  import gpio_change_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyHit,
  input  logic       rdPortStrb,
  input  logic       rdCapStrb,
  input  logic       irqActiveHigh,
  input  logic       irqPushPull,
  output irqStrobe_t strb,
  output logic       pending,
  output logic       irqOut,
  output logic       irqOe
);
  logic clrReq;
  logic pendingQ;

  assign clrReq = rdPortStrb | rdCapStrb;

  // A read wins over a new hit; a hit is taken only when idle
  always_comb begin
    strb.clear = clrReq;
    strb.load  = anyHit & ~pendingQ & ~clrReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pendingQ <= 1'b0;
    else if (clrReq)    pendingQ <= 1'b0;
    else if (strb.load) pendingQ <= 1'b1;
  end

  assign pending = pendingQ;
  assign irqOut  = pendingQ ? irqActiveHigh : ~irqActiveHigh;
  assign irqOe   = irqPushPull | pendingQ;

  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    clrReq |=> !pendingQ) else $error("read did not release"); // R8
  AST_HIT_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (anyHit && !clrReq) |=> pendingQ) else $error("hit did not raise"); // R4
  AST_OD_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (!irqPushPull && !pendingQ) |-> !irqOe) else $error("open-drain driven while idle"); // R11
  AST_ACTIVE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    pendingQ |-> (irqOut == irqActiveHigh)) else $error("wrong active level"); // R10
endmodule

// File: rtl/gpio_change_irq.sv
module gpio_change_irq
  import gpio_change_irq_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] polInv,
  input  logic [WIDTH-1:0] intEn,
  input  logic [WIDTH-1:0] cmpSel,
  input  logic [WIDTH-1:0] defVal,
  input  logic             irqActiveHigh,
  input  logic             irqPushPull,
  input  logic             rdPortStrb,
  input  logic             rdCapStrb,
  output logic [WIDTH-1:0] portVal,
  output logic [WIDTH-1:0] intFlags,
  output logic [WIDTH-1:0] intCapture,
  output logic             irqOut,
  output logic             irqOe
);
  irqStrobe_t       strb;
  logic [WIDTH-1:0] hitVec;
  logic             pending;

  gpio_change_irq_dp #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .polInv(polInv), .intEn(intEn),
    .cmpSel(cmpSel), .defVal(defVal), .strb(strb), .portVal(portVal),
    .hitVec(hitVec), .intFlags(intFlags), .intCapture(intCapture)
  );

  gpio_change_irq_ctl ctl_i (
    .clk(clk), .rstN(rstN), .anyHit(|hitVec), .rdPortStrb(rdPortStrb),
    .rdCapStrb(rdCapStrb), .irqActiveHigh(irqActiveHigh),
    .irqPushPull(irqPushPull), .strb(strb), .pending(pending),
    .irqOut(irqOut), .irqOe(irqOe)
  );

  AST_FROZEN_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !rdPortStrb && !rdCapStrb) |=> ($stable(intFlags) && $stable(intCapture)))
    else $error("flags or snapshot moved while pending"); // R7
  AST_PENDING_HAS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> (intFlags != '0)) else $error("pending with no flag"); // R7
  AST_IDLE_NO_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !pending |-> (intFlags == '0)) else $error("flags left while idle"); // R8
endmodule

// File: tb/gpio_change_irq_tb_top.sv
module gpio_change_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 8;

  typedef struct packed {
    logic [7:0] oldPin, newPin, inv, en, sel, def;
    logic       ah, pp;
  } vec_t;

  // oldPin newPin inv en sel def ah pp  (sel bits chosen so oldPin matches def)
  localparam vec_t VEC [NVEC] = '{
    '{8'h00, 8'h01, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b1},
    '{8'hFF, 8'h0F, 8'h00, 8'hF0, 8'h00, 8'h00, 1'b1, 1'b0},
    '{8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0},
    '{8'h00, 8'h80, 8'h00, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1},
    '{8'h00, 8'h10, 8'h00, 8'hEF, 8'h00, 8'h00, 1'b0, 1'b0},
    '{8'h00, 8'h01, 8'h0F, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b1},
    '{8'h55, 8'hAA, 8'h00, 8'h0F, 8'h0F, 8'h05, 1'b1, 1'b0},
    '{8'h00, 8'h03, 8'h00, 8'h03, 8'h02, 8'h00, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [W-1:0] pinIn = '0, polInv = '0, intEn = '0, cmpSel = '0, defVal = '0;
  logic irqActiveHigh = 1'b0, irqPushPull = 1'b0, rdPortStrb = 1'b0, rdCapStrb = 1'b0;
  logic [W-1:0] portVal, intFlags, intCapture;
  logic irqOut, irqOe;
  int nCmp = 0, nMis = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_change_irq dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .polInv(polInv), .intEn(intEn),
    .cmpSel(cmpSel), .defVal(defVal), .irqActiveHigh(irqActiveHigh),
    .irqPushPull(irqPushPull), .rdPortStrb(rdPortStrb), .rdCapStrb(rdCapStrb),
    .portVal(portVal), .intFlags(intFlags), .intCapture(intCapture),
    .irqOut(irqOut), .irqOe(irqOe)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    nCmp++;
    if (act !== exp) begin
      nMis++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkIrq(input string req, input logic act, input logic ah, input logic pp);
    chk(req, "irqOut", {15'd0, irqOut}, {15'd0, act ? ah : ~ah});
    chk(req, "irqOe",  {15'd0, irqOe},  {15'd0, pp | act});
  endtask

  task automatic readPulse(input bit useCap);
    if (useCap) rdCapStrb = 1'b1; else rdPortStrb = 1'b1;
    @(negedge clk);
    rdCapStrb = 1'b0; rdPortStrb = 1'b0;
  endtask

  initial begin
    vec_t t;
    logic [W-1:0] oldL, newL, expF;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "flags", {8'd0, intFlags}, 16'h0);
    chk("R1", "capture", {8'd0, intCapture}, 16'h0);
    checkIrq("R1", 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // Vector walk: R3 R4 R5 R6 R7 R10 R11
    for (int v = 0; v < NVEC; v++) begin
      t = VEC[v];
      intEn = '0; pinIn = t.oldPin; polInv = t.inv; cmpSel = t.sel; defVal = t.def;
      irqActiveHigh = t.ah; irqPushPull = t.pp;
      repeat (4) @(negedge clk);
      readPulse(1'b0);
      oldL = t.oldPin ^ t.inv;
      newL = t.newPin ^ t.inv;
      expF = t.en & ((t.sel & (newL ^ t.def)) | (~t.sel & (newL ^ oldL)));
      intEn = t.en; pinIn = t.newPin;
      @(negedge clk); @(negedge clk);
      checkIrq("R4 early", 1'b0, t.ah, t.pp);
      @(negedge clk);
      chk("R4 R5 R6", "flags", {8'd0, intFlags}, {8'd0, expF});
      chk("R3", "portVal", {8'd0, portVal}, {8'd0, newL});
      if (expF != '0) chk("R7", "capture", {8'd0, intCapture}, {8'd0, newL});
      checkIrq("R10 R11", expF != '0, t.ah, t.pp);
      intEn = '0;
      readPulse(1'b0);
    end

    // R2: two-edge synchronizer latency
    irqActiveHigh = 1'b1; irqPushPull = 1'b0; polInv = '0; cmpSel = '0;
    pinIn = 8'h01; repeat (3) @(negedge clk);
    pinIn = 8'h03;
    @(negedge clk);
    chk("R2", "portVal after 1 edge", {8'd0, portVal}, 16'h01);
    @(negedge clk);
    chk("R2", "portVal after 2 edges", {8'd0, portVal}, 16'h03);

    // R7: frozen while pending
    pinIn = 8'h00; repeat (4) @(negedge clk); readPulse(1'b0);
    intEn = 8'hFF; pinIn = 8'h02;
    repeat (3) @(negedge clk);
    chk("R7", "flags raised", {8'd0, intFlags}, 16'h02);
    pinIn = 8'h06;
    repeat (4) @(negedge clk);
    chk("R7", "flags frozen", {8'd0, intFlags}, 16'h02);
    chk("R7", "capture frozen", {8'd0, intCapture}, 16'h02);

    // R8: capture-read clears, capture kept, no re-raise in previous-value mode
    readPulse(1'b1);
    chk("R8", "flags cleared", {8'd0, intFlags}, 16'h00);
    chk("R8", "capture kept", {8'd0, intCapture}, 16'h02);
    checkIrq("R8", 1'b0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    checkIrq("R8 stays idle", 1'b0, 1'b1, 1'b0);

    // R9: persistent default mismatch re-raises after a port read
    intEn = '0; pinIn = 8'h01; repeat (4) @(negedge clk); readPulse(1'b0);
    cmpSel = 8'h01; defVal = 8'h00; intEn = 8'h01;
    @(negedge clk);
    chk("R5", "default flag", {8'd0, intFlags}, 16'h01);
    chk("R5", "default capture", {8'd0, intCapture}, 16'h01);
    readPulse(1'b0);
    chk("R9", "cleared flags", {8'd0, intFlags}, 16'h00);
    checkIrq("R9 cleared", 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R9", "reloaded flags", {8'd0, intFlags}, 16'h01);
    checkIrq("R9 re-raised", 1'b1, 1'b1, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nMis);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nCmp++; nMis++;
      $display("FAIL watchdog: actual running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nMis);
      $finish;
    end
  end
endmodule